// File: doc/BRIEF.md
# Chip-Select Pin Driver for an SPI Master

This block drives a bank of chip-select pins for an SPI master. Software programs two registers through a small write/read port. The configuration register chooses which lines serve as chip selects and gives each line its active polarity. The force register asserts or releases individual lines with separate strobe fields.

Each line keeps an internal asserted flag. A force write only touches the lines whose strobe bits are 1. The pin level is worked out from three things: the flag, the select bit and the invert bit. A line that is not selected always sits at its idle level. Its flag is still recorded, and it shows on the pin once the line is selected.

Top module: `cs_pin_unit`

## Requirements
- R1: After reset every pin is high, the configuration register reads 0 and every asserted flag reads 0.
- R2: The configuration register sits at address 0. Bit N+n set means line n acts as a chip select. Bit n set inverts line n. The register reads back exactly what was last written.
- R3: A write to the force register (address 1) with bit n set and bit N+n clear asserts line n. For a selected line without inversion, the pin goes low.
- R4: A force write with bit N+n set releases line n, so its pin returns to the idle level.
- R5: In a force write, a line whose two strobe bits are both 0 keeps its asserted flag and its pin level.
- R6: When one force write has both bit n and bit N+n set, line n ends up released.
- R7: With inversion set, a selected line is active-high: the pin is 1 when asserted and 0 when idle.
- R8: A line that is not selected drives its idle level (1 without inversion, 0 with it) whatever force writes arrive. Its asserted flag is still updated and reads back at address 1 in bits N-1..0.
- R9: A force write of all-ones in the upper half and zeros in the lower half (0xFF00 for N=8) releases every line at once.
- R10: A write changes the pins at the first rising clock edge at which wr_en is sampled high. Reads are combinational from rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 = configuration, 1 = force |
| wr_data | input | 2*N | Write data |
| rd_addr | input | 1 | Read target: 0 = configuration, 1 = asserted flags |
| rd_data | output | 2*N | Read data |
| cs_pin_o | output | N | Chip-select pin levels |

## Verification
Two situations are hard to reach from the ports. One is a force write whose set and clear strobes hit the same line. The other is a flag that changes while its line is not selected, since the pin cannot show that change. The stimulus covers the first case with a write that carries both strobes for a line that was asserted just before. For the second, it deselects every line, forces all flags on, and checks that the pins stay idle. It then reads the flags back and re-selects the lines, so the hidden state appears on the pins.

// File: rtl/cs_pin_unit.sv
module cs_pin_unit #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [2*N-1:0] wr_data,
  input  logic           rd_addr,
  output logic [2*N-1:0] rd_data,
  output logic [N-1:0]   cs_pin_o
);
  localparam logic CFG_ADDR   = 1'b0;
  localparam logic FORCE_ADDR = 1'b1;

  logic [N-1:0] sel_q, inv_q, act_q;
  logic [N-1:0] rel_bits, asrt_bits;

  assign rel_bits  = wr_data[2*N-1:N];
  assign asrt_bits = wr_data[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      inv_q <= '0;
      act_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == CFG_ADDR) begin
        sel_q <= rel_bits;
        inv_q <= asrt_bits;
      end else begin
        act_q <= (act_q | asrt_bits) & ~rel_bits;
      end
    end
  end

  assign cs_pin_o = ~(act_q & sel_q) ^ inv_q;
  assign rd_data  = (rd_addr == FORCE_ADDR) ? {{N{1'b0}}, act_q} : {sel_q, inv_q};
endmodule

// File: rtl/cs_pin_unit_chk.sv
module cs_pin_unit_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           wr_addr,
  input logic [2*N-1:0] wr_data,
  input logic [N-1:0]   cs_pin_o,
  input logic [N-1:0]   sel_q,
  input logic [N-1:0]   inv_q
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (cs_pin_o == {N{1'b1}}));

  for (genvar n = 0; n < N; n++) begin : g_line
    assert_assert_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && wr_data[n] && !wr_data[N+n] && sel_q[n])
      |=> (cs_pin_o[n] == inv_q[n]));

    assert_release_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && wr_data[N+n]) |=> (cs_pin_o[n] == !inv_q[n]));

    assert_untouched_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (!wr_addr || wr_data[n] || wr_data[N+n])) |=> $stable(cs_pin_o[n]));

    assert_unselected_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q[n] |-> (cs_pin_o[n] == !inv_q[n]));
  end
endmodule

bind cs_pin_unit cs_pin_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cs_pin_o(cs_pin_o), .sel_q(sel_q), .inv_q(inv_q)
);

// File: tb/tb_cs_pin_unit.sv
module tb_cs_pin_unit;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic           wr_addr = 1'b0;
  logic [2*N-1:0] wr_data = '0;
  logic           rd_addr = 1'b0;
  logic [2*N-1:0] rd_data;
  logic [N-1:0]   cs_pin_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cs_pin_unit #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cs_pin_o(cs_pin_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [2*N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pins(input string req, input logic [N-1:0] exp);
    chk(req, 32'(cs_pin_o), 32'(exp));
  endtask

  task automatic rd(input string req, input logic a, input logic [2*N-1:0] exp);
    rd_addr = a; #1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset;
    pins("R1 pins", 8'hFF);
    rd("R1 cfg", 1'b0, 16'h0000);
    rd("R1 flags", 1'b1, 16'h0000);
  endtask

  task automatic t_config;
    wr(1'b0, 16'hFF00);
    rd("R2 cfg readback", 1'b0, 16'hFF00);
    pins("R2 pins idle", 8'hFF);
  endtask

  task automatic t_assert_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h0001;
    #1 pins("R10 before edge", 8'hFF);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    pins("R3 R10 line0 asserted", 8'hFE);
    rd("R3 flags", 1'b1, 16'h0001);
  endtask

  task automatic t_keep_release;
    wr(1'b1, 16'h0004);
    pins("R5 line0 kept", 8'hFA);
    wr(1'b1, 16'h0100);
    pins("R4 line0 released", 8'hFB);
  endtask

  task automatic t_both;
    wr(1'b1, 16'h0404);
    pins("R6 both strobes", 8'hFF);
    rd("R6 flags", 1'b1, 16'h0000);
  endtask

  task automatic t_invert;
    wr(1'b0, 16'hFF0F);
    pins("R7 idle inverted", 8'hF0);
    wr(1'b1, 16'h0003);
    pins("R7 active high", 8'hF3);
    wr(1'b1, 16'h0030);
    pins("R7 mixed", 8'hC3);
    wr(1'b1, 16'hFF00);
    pins("R9 all released", 8'hF0);
  endtask

  task automatic t_unselected;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h00FF);
    pins("R8 unselected idle", 8'hFF);
    rd("R8 flags recorded", 1'b1, 16'h00FF);
    wr(1'b0, 16'h0F00);
    pins("R8 partial select", 8'hF0);
    wr(1'b0, 16'hFF00);
    pins("R8 hidden state shown", 8'h00);
    wr(1'b1, 16'hFF00);
    pins("R9 release all", 8'hFF);
    rd("R9 flags", 1'b1, 16'h0000);
  endtask

  initial begin
    #12 t_reset;
    @(negedge clk) rst_n = 1'b1;
    t_config;
    t_assert_timing;
    t_keep_release;
    t_both;
    t_invert;
    t_unselected;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule